// File: doc/BRIEF.md
# Dual-Domain Down-Spread Profile Generator

This block produces the digital frequency-offset profile that steers the fractional divider of a clock synthesizer, so that the synthesized clock sweeps slowly below its nominal rate. That sweep spreads the clock's spectral energy. Two independent domains are served. One is the system/memory clock domain. The other is the serial-link reference domain, which runs at 100 MHz or 125 MHz. Each domain has its own depth selection, its own triangle sequencer and its own signed offset word.

A reference-rate clock enable advances the triangle. The number of enabled ticks per half-period comes from the reference frequency and the target modulation rate. The offset is always zero or negative, because the modulation only pulls the frequency down. Depth codes come from a configuration register. A reserved system code requests no spread and raises a sticky error flag. The link domain never spreads while its 125 MHz mode is selected.

Once a domain is spreading, a request for no spread does not stop it; only reset or the 125 MHz mode does. A new depth requested while spreading waits until the triangle is back at zero offset.

Top module: `spread_profile_gen`

## Requirements
- R1: Each offset output is always in the range from minus the peak magnitude to zero, and it is exactly zero whenever that domain's spread flag is low.
- R2: System code decode, in units of 0.25 %: 3'b000 gives depth 0 (off), 3'b001 gives depth 2, 3'b010 gives depth 3 and 3'b011 gives depth 1. At triangle position k the offset equals -(depth * k * STEP_GAIN).
- R3: Any system code with bit 2 set (3'b100 to 3'b111) is reserved. It requests no spread, and in any clock cycle it sets `sys_code_err`, which stays high until reset.
- R4: Link code decode with `link_sel_100` high: 2'b00 and 2'b11 give depth 0, 2'b01 gives depth 2 and 2'b10 gives depth 3, with the same offset law as the system domain.
- R5: When `link_sel_100` is low (125 MHz mode) in a cycle, the link offset is zero and `link_spread_on` is low from the next clock edge, whatever the link code and `ref_en`. The link domain stays off while the mode is held.
- R6: After a domain's spread flag rises, a code that requests depth 0 (including a reserved system code) leaves its depth unchanged, until reset or, for the link domain, the 125 MHz mode.
- R7: While spreading, the triangle position rises by one per enabled tick from 0 to HALF = REF_HZ/(2*MOD_HZ), then falls by one per tick back to 0, and repeats every 2*HALF ticks. It holds on cycles with `ref_en` low.
- R8: A different nonzero depth requested while spreading takes effect only on the first enabled tick taken at position 0. On that tick the position also moves to 1.
- R9: From the off state, the first enabled tick with a nonzero request sets the depth and raises the spread flag while the position stays at 0. The position starts rising on the following enabled tick.
- R10: During and right after reset, both offsets are zero and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference-rate tick enable |
| sys_code | input | 3 | System/memory domain spread code |
| link_code | input | 2 | Link domain spread code |
| link_sel_100 | input | 1 | 1 = link at 100 MHz, 0 = 125 MHz (no spread) |
| sys_ofs | output | OFS_W | Signed divider offset, system domain |
| sys_spread_on | output | 1 | System domain spreading |
| link_ofs | output | OFS_W | Signed divider offset, link domain |
| link_spread_on | output | 1 | Link domain spreading |
| sys_code_err | output | 1 | Sticky reserved-code flag |

## Verification
The assertions assume that reset is held for at least one clock edge before checking starts, and that the inputs are stable around each rising edge. They allow codes, the mode bit and `ref_en` to change on any cycle and in any combination. The stimulus changes inputs only on falling edges. It changes codes in the middle of a triangle period, leaves gaps in `ref_en`, toggles the 125 MHz mode while spreading, and applies reserved codes both from the off state and while spreading.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // depth in quarter-percent units of down-spread
  typedef logic [1:0] depth_t;

  function automatic depth_t sys_depth(input logic [2:0] code);
    case (code)
      3'b001:  return 2'd2;
      3'b010:  return 2'd3;
      3'b011:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic sys_reserved(input logic [2:0] code);
    return code[2];
  endfunction

  function automatic depth_t link_depth(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // magnitude of the offset at a given triangle position
  function automatic int offset_mag(input int depth, input int pos, input int gain);
    return depth * pos * gain;
  endfunction

endpackage

// File: rtl/ssc_code_decode.sv
module ssc_code_decode
  import ssc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sys_code,
  input  logic [1:0] link_code,
  input  logic       link_sel_100,
  output depth_t     sys_req,
  output depth_t     link_req,
  output logic       link_force_off,
  output logic       sys_code_err
);

  logic reserved_seen;

  assign reserved_seen  = sys_reserved(sys_code);
  assign sys_req        = reserved_seen ? 2'd0 : sys_depth(sys_code);
  assign link_force_off = !link_sel_100;
  assign link_req       = link_sel_100 ? link_depth(link_code) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)             sys_code_err <= 1'b0;
    else if (reserved_seen) sys_code_err <= 1'b1;
  end

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_code_err |=> sys_code_err);

  p_err_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_seen |=> sys_code_err);

  p_reserved_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_seen |-> (sys_req == 2'd0));

endmodule

// File: rtl/ssc_tri_counter.sv
module ssc_tri_counter #(
  parameter int HALF   = 4,
  parameter int STEP_W = $clog2(HALF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              clear,
  output logic [STEP_W-1:0] step,
  output logic              at_zero
);

  localparam logic [STEP_W-1:0] TOP = STEP_W'(HALF);

  logic going_up;

  assign at_zero = (step == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) begin
      step     <= '0;
      going_up <= 1'b1;
    end else if (tick) begin
      if (going_up) begin
        step <= step + 1'b1;
        if (step + 1'b1 == TOP) going_up <= 1'b0;
      end else begin
        step <= step - 1'b1;
        if (step == STEP_W'(1)) going_up <= 1'b1;
      end
    end
  end

  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step <= TOP);

  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && run && !clear) |=> $stable(step));

  p_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !clear) |=>
      ((step == $past(step) + 1'b1) || (step == $past(step) - 1'b1)));

endmodule

// File: rtl/ssc_domain.sv
module ssc_domain
  import ssc_pkg::*;
#(
  parameter int HALF   = 4,
  parameter int GAIN   = 1,
  parameter int OFS_W  = 8,
  parameter int STEP_W = $clog2(HALF + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  depth_t                  req,
  input  logic                    force_off,
  output logic signed [OFS_W-1:0] ofs,
  output logic                    spread_on
);

  depth_t             depth_q;
  logic [STEP_W-1:0]  step;
  logic               at_zero;
  logic               load_evt;

  // a nonzero request loads from the off state at once, or at zero offset
  assign load_evt  = tick && !force_off && (req != 2'd0) &&
                     ((depth_q == 2'd0) || at_zero);
  assign spread_on = (depth_q != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || force_off) depth_q <= 2'd0;
    else if (load_evt)       depth_q <= req;
  end

  ssc_tri_counter #(.HALF(HALF), .STEP_W(STEP_W)) u_tri (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (spread_on),
    .clear   (force_off),
    .step    (step),
    .at_zero (at_zero)
  );

  assign ofs = OFS_W'(-offset_mag(int'(depth_q), int'(step), GAIN));

  p_down_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ofs[OFS_W-1] && (ofs != '0)));

  p_off_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_on |-> (ofs == '0));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_on && !force_off) |=> spread_on);

  p_change_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_on && !at_zero) |=> (!spread_on || $stable(depth_q)));

  p_force_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !spread_on);

  p_start_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!spread_on && load_evt) |=> (spread_on && at_zero));

endmodule

// File: rtl/spread_profile_gen.sv
module spread_profile_gen
  import ssc_pkg::*;
#(
  parameter int REF_HZ    = 25_000_000,
  parameter int MOD_HZ    = 31_500,
  parameter int STEP_GAIN = 1,
  parameter int OFS_W     = $clog2(3 * (REF_HZ / (2 * MOD_HZ)) * STEP_GAIN + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_en,
  input  logic [2:0]              sys_code,
  input  logic [1:0]              link_code,
  input  logic                    link_sel_100,
  output logic signed [OFS_W-1:0] sys_ofs,
  output logic                    sys_spread_on,
  output logic signed [OFS_W-1:0] link_ofs,
  output logic                    link_spread_on,
  output logic                    sys_code_err
);

  localparam int HALF   = REF_HZ / (2 * MOD_HZ);
  localparam int STEP_W = $clog2(HALF + 1);
  localparam int NDOM   = 2;

  depth_t                  dom_req   [NDOM];
  logic                    dom_force [NDOM];
  logic signed [OFS_W-1:0] dom_ofs   [NDOM];
  logic                    dom_on    [NDOM];
  depth_t                  sys_req_w;
  depth_t                  link_req_w;
  logic                    link_force_w;

  ssc_code_decode u_dec (
    .clk            (clk),
    .rst_n          (rst_n),
    .sys_code       (sys_code),
    .link_code      (link_code),
    .link_sel_100   (link_sel_100),
    .sys_req        (sys_req_w),
    .link_req       (link_req_w),
    .link_force_off (link_force_w),
    .sys_code_err   (sys_code_err)
  );

  assign dom_req[0]   = sys_req_w;
  assign dom_force[0] = 1'b0;
  assign dom_req[1]   = link_req_w;
  assign dom_force[1] = link_force_w;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    ssc_domain #(
      .HALF   (HALF),
      .GAIN   (STEP_GAIN),
      .OFS_W  (OFS_W),
      .STEP_W (STEP_W)
    ) u_dom (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (ref_en),
      .req       (dom_req[d]),
      .force_off (dom_force[d]),
      .ofs       (dom_ofs[d]),
      .spread_on (dom_on[d])
    );
  end

  assign sys_ofs        = dom_ofs[0];
  assign sys_spread_on  = dom_on[0];
  assign link_ofs       = dom_ofs[1];
  assign link_spread_on = dom_on[1];

  p_link_125_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !link_sel_100 |=> (!link_spread_on && (link_ofs == '0)));

endmodule

// File: tb/spread_profile_gen_tb.sv
module spread_profile_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 4000;
  localparam int MOD_HZ     = 500;
  localparam int GAIN       = 1;
  localparam int HALF       = REF_HZ / (2 * MOD_HZ);
  localparam int OFS_W      = $clog2(3 * HALF * GAIN + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic [2:0] sys_code = 3'b000;
  logic [1:0] link_code = 2'b00;
  logic link_sel_100 = 1'b1;
  logic signed [OFS_W-1:0] sys_ofs, link_ofs;
  logic sys_spread_on, link_spread_on, sys_code_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  spread_profile_gen #(.REF_HZ(REF_HZ), .MOD_HZ(MOD_HZ), .STEP_GAIN(GAIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .sys_code(sys_code),
    .link_code(link_code), .link_sel_100(link_sel_100),
    .sys_ofs(sys_ofs), .sys_spread_on(sys_spread_on),
    .link_ofs(link_ofs), .link_spread_on(link_spread_on),
    .sys_code_err(sys_code_err)
  );

  typedef struct packed {
    logic signed [OFS_W-1:0] so;
    logic                    son;
    logic signed [OFS_W-1:0] lo;
    logic                    lon;
    logic                    err;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model: depth per domain and ticks since the domain started
  int  m_d[2];
  int  m_t[2];
  bit  m_err;

  function automatic int tri_pos(input int t);
    int ph;
    ph = t % (2 * HALF);
    return (ph <= HALF) ? ph : (2 * HALF - ph);
  endfunction

  function automatic int sys_q(input logic [2:0] c);
    if (c == 3'b001) return 2;
    if (c == 3'b010) return 3;
    if (c == 3'b011) return 1;
    return 0;
  endfunction

  function automatic int link_q(input logic [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b10) return 3;
    return 0;
  endfunction

  task automatic model_dom(input int i, input bit tick, input int req, input bit force_off);
    if (force_off) begin
      m_d[i] = 0; m_t[i] = 0;
    end else if (tick) begin
      if (m_d[i] == 0) begin
        if (req != 0) begin m_d[i] = req; m_t[i] = 0; end
      end else begin
        if ((m_t[i] % (2 * HALF)) == 0 && req != 0) m_d[i] = req;
        m_t[i] = m_t[i] + 1;
      end
    end
  endtask

  function automatic exp_t model_out();
    exp_t e;
    e.so  = OFS_W'(-(m_d[0] * tri_pos(m_t[0]) * GAIN));
    e.son = (m_d[0] != 0);
    e.lo  = OFS_W'(-(m_d[1] * tri_pos(m_t[1]) * GAIN));
    e.lon = (m_d[1] != 0);
    e.err = m_err;
    return e;
  endfunction

  task automatic model_reset();
    m_d[0] = 0; m_d[1] = 0; m_t[0] = 0; m_t[1] = 0; m_err = 0;
  endtask

  // driver: one clock of stimulus, expected result queued for the monitor
  task automatic cyc(input bit en, input logic [2:0] sc, input logic [1:0] lc,
                     input bit s100, input string tag);
    @(negedge clk);
    ref_en = en; sys_code = sc; link_code = lc; link_sel_100 = s100;
    model_dom(0, en, sc[2] ? 0 : sys_q(sc), 1'b0);
    model_dom(1, en, s100 ? link_q(lc) : 0, !s100);
    if (sc[2]) m_err = 1;
    q_exp.push_back(model_out());
    q_tag.push_back(tag);
  endtask

  task automatic compare(input exp_t e, input string tag);
    n_checks++;
    if (sys_ofs !== e.so || sys_spread_on !== e.son || link_ofs !== e.lo ||
        link_spread_on !== e.lon || sys_code_err !== e.err) begin
      n_fail++;
      $display("FAIL %s: got sys=%0d/%0b link=%0d/%0b err=%0b exp sys=%0d/%0b link=%0d/%0b err=%0b",
               tag, sys_ofs, sys_spread_on, link_ofs, link_spread_on, sys_code_err,
               e.so, e.son, e.lo, e.lon, e.err);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) compare(q_exp.pop_front(), q_tag.pop_front());
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_en = 1'b0; sys_code = 3'b000; link_code = 2'b00; link_sel_100 = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    compare(model_out(), "R10 reset state");
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, 3'b000, 2'b00, 1, "R10 idle zero");
    // R2 R4 R9 R7 R1: start both domains and run over two periods
    for (int i = 0; i < 20; i++) cyc(1, 3'b001, 2'b01, 1, "R2 R4 R7 R9 R1");
    // R7: gaps in the tick enable hold the position
    for (int i = 0; i < 12; i++) cyc((i % 3) != 0, 3'b001, 2'b01, 1, "R7 tick gaps");
    // R8: depth change mid-period waits for zero offset
    for (int i = 0; i < 20; i++) cyc(1, 3'b010, 2'b10, 1, "R8 R2 R4 change at zero");
    // R6: no-spread requests do not stop an active domain
    for (int i = 0; i < 12; i++) cyc(1, 3'b000, 2'b11, 1, "R6 lock");
    for (int i = 0; i < 6; i++)  cyc(1, 3'b101, 2'b00, 1, "R3 R6 reserved while on");
    // R5: 125 MHz mode forces the link domain off
    for (int i = 0; i < 6; i++)  cyc(i % 2, 3'b000, 2'b01, 0, "R5 forced off");
    for (int i = 0; i < 6; i++)  cyc(1, 3'b000, 2'b00, 1, "R5 stays off");
    for (int i = 0; i < 10; i++) cyc(1, 3'b000, 2'b01, 1, "R9 link restart");
    for (int i = 0; i < 2; i++)  cyc(0, 3'b000, 2'b00, 1, "R6 drain");
    do_reset();
    // R3: reserved code from off keeps spread off and sets the flag
    for (int i = 0; i < 6; i++)  cyc(1, 3'b110, 2'b00, 1, "R3 reserved from off");
    for (int i = 0; i < 18; i++) cyc(1, 3'b011, 2'b00, 1, "R2 depth one R3 sticky");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule